// File: doc/BRIEF.md
# Dual-Core Shared Memory Partitioner

Two identical processor cores share four on-chip memories: a program store, a coefficient store, a data store and a delay-line store. Each memory has a mode setting that decides how many words each core owns. The partitioner holds these settings and maps each core's local word address onto the one physical array. It also stops any access that falls outside the owning core's share, or that targets a memory the core is not connected to.

Core 0's share always starts at physical word 0. Core 1's share starts right after core 0's share. Some modes hand a whole memory to core 0. In those modes core 1 has no program, coefficient or data words, so the block keeps core 1 in reset through its hold output. A mode can be changed only while both cores are in reset.

Each core drives a request with a memory select, an address, a write flag and write data. The partitioner passes a translated request to the RAM, either in the same cycle or not at all. One cycle later it returns the RAM read data, or an error pulse if the request was stopped.

Top module: `shmp_partitioner`

## Requirements
- R1: After a synchronous reset every memory is in mode 0. Program and data are then split 2048/2048, coefficient is split 4096 (core 0) / 2048 (core 1), all 12288 delay-line words belong to core 0, and neither hold output is set.
- R2: A configuration write (cfg_we with cfg_sel, cfg_val) takes effect at the next clock edge only if each core is in reset at that time. A core counts as in reset when its core_rst_req bit is set or its core_hold bit is set. Any other configuration write is ignored.
- R3: Program memory (select 0) uses cfg_val bit 0. Mode 0 gives 2048 words to each core. Mode 1 gives all 4096 words to core 0 and none to core 1.
- R4: Coefficient memory (select 1) uses cfg_val[1:0]. Mode 0 gives 4096/2048, mode 1 gives 2048/4096 and mode 2 gives 6144/0 (core 0 / core 1). Writing value 3 leaves the previous mode in place.
- R5: Data memory (select 2) uses cfg_val bit 0. Mode 0 gives 2048 words to each core. Mode 1 gives all 4096 words to core 0.
- R6: Delay-line memory (select 3) uses cfg_val[1:0]. The splits (core 0 / core 1) are: mode 0 gives 12288/0, mode 1 gives 8192/4096, mode 2 gives 4096/8192 and mode 3 gives 0/12288. A share of 0 means that core is unconnected.
- R7: A granted access from core 0 uses physical address = local address. A granted access from core 1 uses physical address = local address + core 0's share of that memory. m_mem repeats the request's memory select in the same cycle.
- R8: A request is granted only when the local address is below the core's share and the core is not held. A request that is not granted leaves m_en and m_we low.
- R9: A request that is not granted raises c_err for that core in the following cycle only.
- R10: In the cycle after a granted read, c_rdata carries the RAM data. In every other cycle, c_rdata is zero.
- R11: core_hold of a core is set whenever the current modes give it zero words of program, coefficient or data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_rst_req | input | 2 | Per core: the system holds that core in reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Memory to configure (0 program, 1 coefficient, 2 data, 3 delay-line) |
| cfg_val | input | 2 | New mode value |
| core_hold | output | 2 | Per core: forced reset because the core lacks a required memory |
| c_req | input | 2 | Per core: access request |
| c_mem | input | 2x2 | Per core: memory select, same encoding as cfg_sel |
| c_addr | input | 2xAW | Per core: local word address |
| c_we | input | 2 | Per core: write flag |
| c_wdata | input | 2xDATA_W | Per core: write data |
| c_rdata | output | 2xDATA_W | Per core: read data, one cycle after the request |
| c_err | output | 2 | Per core: blocked-access pulse, one cycle after the request |
| m_en | output | 2 | Per core port of the RAM: enable |
| m_mem | output | 2x2 | Per core port of the RAM: memory select |
| m_addr | output | 2xAW | Per core port of the RAM: physical word address |
| m_we | output | 2 | Per core port of the RAM: write enable |
| m_wdata | output | 2xDATA_W | Per core port of the RAM: write data |
| m_rdata | input | 2xDATA_W | Per core port of the RAM: read data, one cycle after enable |

## Verification
The assertions check, on every cycle, the rules that hold whatever the mode:

- a held core never reaches the RAM;
- the two cores' physical addresses in the same memory never collide;
- every physical address stays inside the array;
- an error pulse always follows a request and comes with zero read data;
- the hold outputs change only while both cores are in reset.

Only the bench's scenarios can show that each mode gives the exact split and base offset, including the 4096/8192 delay-line split and the rejected reserved coefficient value. The same holds for writes refused while a core runs, and for data written through one mode being read back at the right physical word.

// File: rtl/shmp_pkg.sv
package shmp_pkg;

    localparam int NCORE = 2;

    typedef enum logic [1:0] {
        MEM_PROG = 2'd0,
        MEM_COEF = 2'd1,
        MEM_DATA = 2'd2,
        MEM_DLY  = 2'd3
    } mem_e;

    typedef struct packed {
        logic       prog;
        logic [1:0] coef;
        logic       data;
        logic [1:0] dly;
    } modes_t;

    // Share of one memory owned by one core, in units of UNIT_WORDS.
    function automatic logic [2:0] share_units(mem_e m, modes_t md, logic core);
        logic [2:0] u;
        u = 3'd0;
        case (m)
            MEM_PROG: u = md.prog ? (core ? 3'd0 : 3'd2) : 3'd1;
            MEM_DATA: u = md.data ? (core ? 3'd0 : 3'd2) : 3'd1;
            MEM_COEF: begin
                case (md.coef)
                    2'b00:   u = core ? 3'd1 : 3'd2;
                    2'b01:   u = core ? 3'd2 : 3'd1;
                    2'b10:   u = core ? 3'd0 : 3'd3;
                    default: u = 3'd0;
                endcase
            end
            MEM_DLY: begin
                case (md.dly)
                    2'b00:   u = core ? 3'd0 : 3'd6;
                    2'b01:   u = core ? 3'd2 : 3'd4;
                    2'b10:   u = core ? 3'd4 : 3'd2;
                    default: u = core ? 3'd6 : 3'd0;
                endcase
            end
            default: u = 3'd0;
        endcase
        return u;
    endfunction

    // Full size of each shared array, in units.
    function automatic logic [2:0] total_units(mem_e m);
        case (m)
            MEM_PROG: return 3'd2;
            MEM_COEF: return 3'd3;
            MEM_DATA: return 3'd2;
            default:  return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/shmp_mode_regs.sv
module shmp_mode_regs
    import shmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] core_rst_req,
    input  logic             cfg_we,
    input  mem_e             cfg_sel,
    input  logic [1:0]       cfg_val,
    output modes_t           modes,
    output logic [NCORE-1:0] hold
);

    logic all_quiet;
    logic wr_ok;

    for (genvar c = 0; c < NCORE; c++) begin : g_hold
        always_comb begin
            hold[c] = (share_units(MEM_PROG, modes, 1'(c)) == 3'd0)
                    | (share_units(MEM_COEF, modes, 1'(c)) == 3'd0)
                    | (share_units(MEM_DATA, modes, 1'(c)) == 3'd0);
        end
    end

    assign all_quiet = &(core_rst_req | hold);
    assign wr_ok     = cfg_we & all_quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            modes <= '0;
        end else if (wr_ok) begin
            case (cfg_sel)
                MEM_PROG: modes.prog <= cfg_val[0];
                MEM_COEF: if (cfg_val != 2'b11) modes.coef <= cfg_val;
                MEM_DATA: modes.data <= cfg_val[0];
                default:  modes.dly  <= cfg_val;
            endcase
        end
    end

endmodule

// File: rtl/shmp_xlate.sv
module shmp_xlate
    import shmp_pkg::*;
#(
    parameter  int UNIT_WORDS = 2048,
    parameter  int DATA_W     = 24,
    parameter  int CORE       = 0,
    localparam int AW         = $clog2(6 * UNIT_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  modes_t            modes,
    input  logic              held,
    input  logic              req,
    input  mem_e              mem,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              m_en,
    output mem_e              m_mem,
    output logic [AW-1:0]     m_addr,
    output logic              m_we,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    localparam int AWP = AW + 1;

    logic [AWP-1:0] size;
    logic [AWP-1:0] base;
    logic           in_range;
    logic           grant;
    logic           rd_ok_q;
    logic           err_q;

    always_comb begin
        size = AWP'(share_units(mem, modes, 1'(CORE)) * UNIT_WORDS);
        if (CORE == 0) begin
            base = '0;
        end else begin
            base = AWP'(share_units(mem, modes, 1'b0) * UNIT_WORDS);
        end
    end

    assign in_range = ({1'b0, addr} < size);
    assign grant    = req & in_range & ~held;

    assign m_en    = grant;
    assign m_we    = grant & we;
    assign m_mem   = mem;
    assign m_addr  = AW'({1'b0, addr} + base);
    assign m_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ok_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            rd_ok_q <= grant & ~we;
            err_q   <= req & ~grant;
        end
    end

    assign rdata = rd_ok_q ? m_rdata : '0;
    assign err   = err_q;

endmodule

// File: rtl/shmp_partitioner.sv
module shmp_partitioner
    import shmp_pkg::*;
#(
    parameter  int UNIT_WORDS = 2048,
    parameter  int DATA_W     = 24,
    localparam int AW         = $clog2(6 * UNIT_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   core_rst_req,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_sel,
    input  logic [1:0]                   cfg_val,
    output logic [1:0]                   core_hold,
    input  logic [1:0]                   c_req,
    input  logic [1:0][1:0]              c_mem,
    input  logic [1:0][AW-1:0]           c_addr,
    input  logic [1:0]                   c_we,
    input  logic [1:0][DATA_W-1:0]       c_wdata,
    output logic [1:0][DATA_W-1:0]       c_rdata,
    output logic [1:0]                   c_err,
    output logic [1:0]                   m_en,
    output logic [1:0][1:0]              m_mem,
    output logic [1:0][AW-1:0]           m_addr,
    output logic [1:0]                   m_we,
    output logic [1:0][DATA_W-1:0]       m_wdata,
    input  logic [1:0][DATA_W-1:0]       m_rdata
);

    modes_t modes;

    shmp_mode_regs u_modes (
        .clk          (clk),
        .rst          (rst),
        .core_rst_req (core_rst_req),
        .cfg_we       (cfg_we),
        .cfg_sel      (mem_e'(cfg_sel)),
        .cfg_val      (cfg_val),
        .modes        (modes),
        .hold         (core_hold)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        mem_e mem_out;

        shmp_xlate #(
            .UNIT_WORDS (UNIT_WORDS),
            .DATA_W     (DATA_W),
            .CORE       (c)
        ) u_xlate (
            .clk     (clk),
            .rst     (rst),
            .modes   (modes),
            .held    (core_hold[c]),
            .req     (c_req[c]),
            .mem     (mem_e'(c_mem[c])),
            .addr    (c_addr[c]),
            .we      (c_we[c]),
            .wdata   (c_wdata[c]),
            .m_en    (m_en[c]),
            .m_mem   (mem_out),
            .m_addr  (m_addr[c]),
            .m_we    (m_we[c]),
            .m_wdata (m_wdata[c]),
            .m_rdata (m_rdata[c]),
            .rdata   (c_rdata[c]),
            .err     (c_err[c])
        );

        assign m_mem[c] = mem_out;
    end

endmodule

// File: rtl/shmp_partitioner_chk.sv
module shmp_partitioner_chk
    import shmp_pkg::*;
#(
    parameter  int UNIT_WORDS = 2048,
    parameter  int DATA_W     = 24,
    localparam int AW         = $clog2(6 * UNIT_WORDS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             core_rst_req,
    input logic [1:0]             core_hold,
    input logic [1:0]             c_req,
    input logic [1:0][DATA_W-1:0] c_rdata,
    input logic [1:0]             c_err,
    input logic [1:0]             m_en,
    input logic [1:0][1:0]        m_mem,
    input logic [1:0][AW-1:0]     m_addr
);

    for (genvar c = 0; c < NCORE; c++) begin : g_chk
        logic [AW:0] limit;
        assign limit = (AW+1)'(total_units(mem_e'(m_mem[c])) * UNIT_WORDS);

        // R11 / R8: a held core never reaches the RAM
        a_r11_held_core_silent: assert property (@(posedge clk) disable iff (rst)
            core_hold[c] |-> !m_en[c]);

        // R9: an error pulse is always caused by a request one cycle earlier
        a_r9_err_follows_req: assert property (@(posedge clk) disable iff (rst)
            c_err[c] |-> $past(c_req[c]));

        // R10: a blocked access returns zero data
        a_r10_err_zero_data: assert property (@(posedge clk) disable iff (rst)
            c_err[c] |-> (c_rdata[c] == '0));

        // R6 / R7: a translated address stays inside its array
        a_r7_addr_in_array: assert property (@(posedge clk) disable iff (rst)
            m_en[c] |-> ({1'b0, m_addr[c]} < limit));
    end

    // R7: the two shares of one memory never overlap
    a_r7_no_collision: assert property (@(posedge clk) disable iff (rst)
        (m_en[0] && m_en[1] && m_mem[0] == m_mem[1]) |-> (m_addr[0] != m_addr[1]));

    // R2: the hold pattern only moves while both cores were in reset
    a_r2_hold_frozen_running: assert property (@(posedge clk) disable iff (rst)
        !$past(&(core_rst_req | core_hold)) |-> $stable(core_hold));

endmodule

bind shmp_partitioner shmp_partitioner_chk #(
    .UNIT_WORDS (UNIT_WORDS),
    .DATA_W     (DATA_W)
) u_chk (.*);

// File: tb/shmp_partitioner_bench.sv
module shmp_partitioner_bench;

    localparam int AW = 14;
    localparam int DW = 24;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [1:0]            core_rst_req;
    logic                  cfg_we;
    logic [1:0]            cfg_sel;
    logic [1:0]            cfg_val;
    logic [1:0]            core_hold;
    logic [1:0]            c_req;
    logic [1:0][1:0]       c_mem;
    logic [1:0][AW-1:0]    c_addr;
    logic [1:0]            c_we;
    logic [1:0][DW-1:0]    c_wdata;
    logic [1:0][DW-1:0]    c_rdata;
    logic [1:0]            c_err;
    logic [1:0]            m_en;
    logic [1:0][1:0]       m_mem;
    logic [1:0][AW-1:0]    m_addr;
    logic [1:0]            m_we;
    logic [1:0][DW-1:0]    m_wdata;
    logic [1:0][DW-1:0]    m_rdata = '0;

    always #4 clk = ~clk;

    shmp_partitioner u_shmp_partitioner (.*);

    // RAM model: one port per core, read data one cycle after enable
    logic [DW-1:0] ram [int];

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (m_en[c]) begin
                int k;
                k = int'(m_mem[c]) * 65536 + int'(m_addr[c]);
                m_rdata[c] <= ram.exists(k) ? ram[k] : '0;
                if (m_we[c]) ram[k] = m_wdata[c];
            end
        end
    end

    // Reference model state
    int            pm, cm, dm, lm;
    logic [DW-1:0] shadow [int];
    logic [1:0]    exp_err;
    logic [1:0][DW-1:0] exp_rd;
    int            vectors = 0;
    int            fails = 0;
    string         phase = "R1";

    function automatic int words(int mem, int core);
        case (mem)
            0: return (pm == 0) ? 2048 : ((core == 0) ? 4096 : 0);
            1: begin
                if (cm == 0) return (core == 0) ? 4096 : 2048;
                if (cm == 1) return (core == 0) ? 2048 : 4096;
                return (core == 0) ? 6144 : 0;
            end
            2: return (dm == 0) ? 2048 : ((core == 0) ? 4096 : 0);
            default: begin
                if (lm == 0) return (core == 0) ? 12288 : 0;
                if (lm == 1) return (core == 0) ? 8192 : 4096;
                if (lm == 2) return (core == 0) ? 4096 : 8192;
                return (core == 0) ? 0 : 12288;
            end
        endcase
    endfunction

    function automatic bit held(int core);
        return words(0, core) == 0 || words(1, core) == 0 || words(2, core) == 0;
    endfunction

    task automatic chk(string req, int core, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) core%0d: actual %0h expected %0h", req, phase, core, act, exp);
        end
    endtask

    task automatic clr();
        cfg_we = 1'b0; cfg_sel = '0; cfg_val = '0;
        c_req = '0; c_mem = '0; c_addr = '0; c_we = '0; c_wdata = '0;
    endtask

    task automatic acc(int core, int mem, int addr, bit we, int wd);
        c_req[core]   = 1'b1;
        c_mem[core]   = 2'(mem);
        c_addr[core]  = AW'(addr);
        c_we[core]    = we;
        c_wdata[core] = DW'(wd);
    endtask

    task automatic cfg(int sel, int val);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_val = 2'(val);
    endtask

    // Compare this cycle, advance the model, move to the next falling edge
    task automatic tick(bit do_check);
        bit [1:0] ok;
        int       phys [2];
        bit       quiet;
        #1;
        for (int c = 0; c < 2; c++) begin
            int m, sz;
            m  = int'(c_mem[c]);
            sz = words(m, c);
            ok[c]   = c_req[c] && !held(c) && (int'(c_addr[c]) < sz);
            phys[c] = int'(c_addr[c]) + ((c == 1) ? words(m, 0) : 0);
            if (do_check) begin
                chk("R11", c, core_hold[c], held(c));
                chk("R8", c, m_en[c], ok[c]);
                chk("R8", c, m_we[c], ok[c] && c_we[c]);
                if (ok[c]) begin
                    chk("R7", c, m_addr[c], phys[c]);
                    chk("R7", c, m_mem[c], m);
                end
                chk("R9", c, c_err[c], exp_err[c]);
                chk("R10", c, c_rdata[c], exp_rd[c]);
            end
        end
        if (rst) begin
            exp_err = '0; exp_rd = '0;
            pm = 0; cm = 0; dm = 0; lm = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                int k;
                k = int'(c_mem[c]) * 65536 + phys[c];
                exp_err[c] = c_req[c] && !ok[c];
                exp_rd[c]  = (ok[c] && !c_we[c]) ? (shadow.exists(k) ? shadow[k] : '0) : '0;
            end
            for (int c = 0; c < 2; c++) begin
                if (ok[c] && c_we[c]) shadow[int'(c_mem[c]) * 65536 + phys[c]] = c_wdata[c];
            end
            quiet = (core_rst_req[0] || held(0)) && (core_rst_req[1] || held(1));
            if (cfg_we && quiet) begin
                case (int'(cfg_sel))
                    0: pm = int'(cfg_val[0]);
                    1: if (cfg_val != 2'b11) cm = int'(cfg_val);
                    2: dm = int'(cfg_val[0]);
                    default: lm = int'(cfg_val);
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst = 1'b1; core_rst_req = '0; exp_err = '0; exp_rd = '0;
        pm = 0; cm = 0; dm = 0; lm = 0;
        clr();
        @(negedge clk);
        tick(1'b0);
        // R1: reset state checked during the remaining reset cycles
        tick(1'b1); tick(1'b1);
        rst = 1'b0;

        // R1 / R7: default splits, writes at share edges
        phase = "R1";
        clr(); acc(0, 0, 5, 1, 'h111); acc(1, 0, 2047, 1, 'h222); tick(1'b1);
        clr(); acc(0, 1, 4095, 1, 'h333); acc(1, 1, 2047, 1, 'h444); tick(1'b1);
        clr(); acc(0, 3, 12287, 1, 'h555); acc(1, 2, 0, 1, 'h666); tick(1'b1);
        clr(); acc(0, 0, 5, 0, 0); acc(1, 0, 2047, 0, 0); tick(1'b1);
        clr(); acc(0, 3, 12287, 0, 0); acc(1, 1, 2047, 0, 0); tick(1'b1);
        // R8 / R9: out of range and unconnected delay line for core 1
        phase = "R8";
        clr(); acc(0, 0, 2048, 1, 'h777); acc(1, 3, 0, 0, 0); tick(1'b1);
        clr(); acc(1, 1, 2048, 0, 0); tick(1'b1);
        clr(); tick(1'b1);

        // R2: configuration refused while cores run
        phase = "R2";
        clr(); cfg(0, 1); tick(1'b1);
        core_rst_req = 2'b10;
        clr(); cfg(0, 1); tick(1'b1);
        core_rst_req = 2'b00;
        clr(); acc(1, 0, 2047, 0, 0); tick(1'b1);
        clr(); tick(1'b1);

        // R4 / R6: reserved coefficient value, asymmetric splits
        phase = "R4";
        core_rst_req = 2'b11;
        clr(); cfg(1, 1); tick(1'b1);
        clr(); cfg(1, 3); tick(1'b1);
        clr(); cfg(3, 1); tick(1'b1);
        core_rst_req = 2'b00;
        clr(); acc(1, 1, 4095, 1, 'hABC); acc(0, 1, 2048, 0, 0); tick(1'b1);
        clr(); acc(1, 1, 4095, 0, 0); acc(0, 1, 2047, 1, 'hDEF); tick(1'b1);
        phase = "R6";
        clr(); acc(1, 3, 4095, 1, 'h123); acc(0, 3, 8191, 1, 'h456); tick(1'b1);
        clr(); acc(1, 3, 4096, 0, 0); acc(0, 3, 8192, 0, 0); tick(1'b1);
        clr(); acc(1, 3, 4095, 0, 0); acc(0, 3, 8191, 0, 0); tick(1'b1);
        core_rst_req = 2'b11;
        clr(); cfg(3, 2); tick(1'b1);
        core_rst_req = 2'b00;
        clr(); acc(1, 3, 8191, 0, 0); acc(0, 3, 4095, 0, 0); tick(1'b1);
        clr(); acc(1, 3, 8192, 0, 0); tick(1'b1);
        core_rst_req = 2'b11;
        clr(); cfg(3, 3); tick(1'b1);
        core_rst_req = 2'b00;
        clr(); acc(0, 3, 0, 0, 0); acc(1, 3, 12287, 1, 'h9); tick(1'b1);
        clr(); tick(1'b1);

        // R3 / R11: program to core 0 only, core 1 held
        phase = "R3";
        core_rst_req = 2'b11;
        clr(); cfg(0, 1); tick(1'b1);
        core_rst_req = 2'b00;
        clr(); acc(0, 0, 4095, 1, 'h42); acc(1, 0, 0, 0, 0); tick(1'b1);
        clr(); acc(0, 0, 4095, 0, 0); acc(1, 2, 0, 0, 0); tick(1'b1);
        // R2: core 1 held, core 0 running -> refused
        phase = "R2";
        clr(); cfg(0, 0); tick(1'b1);
        core_rst_req = 2'b01;
        clr(); cfg(0, 0); tick(1'b1);
        core_rst_req = 2'b00;
        clr(); acc(1, 0, 100, 0, 0); tick(1'b1);

        // R5 and coefficient mode 2
        phase = "R5";
        core_rst_req = 2'b11;
        clr(); cfg(2, 1); tick(1'b1);
        core_rst_req = 2'b00;
        clr(); acc(0, 2, 4095, 1, 'h77); tick(1'b1);
        clr(); acc(0, 2, 4095, 0, 0); acc(1, 2, 1, 0, 0); tick(1'b1);
        core_rst_req = 2'b11;
        clr(); cfg(2, 0); tick(1'b1);
        clr(); cfg(1, 2); tick(1'b1);
        core_rst_req = 2'b00;
        phase = "R4";
        clr(); acc(0, 1, 6143, 0, 0); acc(1, 1, 0, 0, 0); tick(1'b1);
        clr(); tick(1'b1);

        // Random traffic and reconfiguration (R2..R11 together)
        phase = "R10";
        for (int i = 0; i < 3000; i++) begin
            clr();
            core_rst_req = ($urandom_range(0, 7) == 0) ? 2'(($urandom_range(0, 3))) : 2'b00;
            if ($urandom_range(0, 9) == 0) cfg($urandom_range(0, 3), $urandom_range(0, 3));
            for (int c = 0; c < 2; c++) begin
                if ($urandom_range(0, 2) != 0) begin
                    int a;
                    a = ($urandom_range(0, 3) == 0) ? ((int'($urandom_range(1, 6)) * 2048) - int'($urandom_range(0, 1)))
                                                    : int'($urandom_range(0, 12287));
                    acc(c, $urandom_range(0, 3), a, 1'($urandom_range(0, 1)), int'($urandom));
                end
            end
            tick(1'b1);
        end
        clr(); core_rst_req = '0; tick(1'b1);
        report();
    end

endmodule